// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a small multicycle 32-bit processor. The processor has a 32-entry register file with one read port, a program counter, an instruction register, a data register, an address register and one memory that holds both instructions and data. The controller is a Moore machine. It takes the opcode and function fields of the instruction register and the ALU zero flag. From them it steps each instruction through fetch, PC increment, decode and a short execute tail. Every cycle it drives thirteen datapath commands: five write strobes, the register-file address and data selects, the ALU operand selects, the ALU operation code, the memory address select and the memory request code.

Five instructions are supported: add, add-immediate, load word, store word and branch-if-equal. Any other encoding traps the controller in an error state. The register file has one read port, so an instruction that needs two register operands first parks rs in the address register. It reads rt in a later cycle. The reset input is asynchronous and active low. Its release passes through a short synchronizer before the state register leaves fetch.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While reset is asserted, and until its synchronized release, the outputs are those of fetch: ir_we=1, mem_req=1 (read), mem_addr_sel=0 (PC), and pc_we, ad_we, dt_we, rf_we all 0.
- R2: Every instruction starts with one fetch cycle. The next cycle has pc_we=1, alu_a_sel=0 (PC), alu_b_sel=0 (constant 4) and alu_op=2 (add). The cycle after that is a decode cycle with no strobe. The opcode is IR[31:26] and the function field is IR[5:0].
- R3: add (opcode 0x00 with function 0x20) takes 5 cycles. First rs (rf_rsel=0) plus zero (alu_b_sel=4) is stored in the address register. Then rt (rf_rsel=1, alu_a_sel=1) plus the address register (alu_b_sel=2) is written to rd (rf_wsel=1, rf_dsel=0 for the ALU result).
- R4: add-immediate (opcode 0x08) takes 4 cycles. It writes rs plus the sign-extended IR[15:0] (alu_b_sel=1) to rt (rf_wsel=0).
- R5: load word (opcode 0x23) takes 6 cycles. The address register takes rs plus the sign-extended offset. A read is then made at that address (mem_addr_sel=1, mem_req=1, dt_we=1). Finally the data register is written to rt (rf_dsel=1).
- R6: store word (opcode 0x2B) takes 5 cycles. The address is formed as in R5, then mem_req=2 (write) is issued at the address register, with rt on the read port (rf_rsel=1) as the write data.
- R7: branch-if-equal (opcode 0x04) parks rs, then computes rt minus the parked value with alu_op=6 (subtract). If alu_zero is set, one more cycle adds the sign-extended offset shifted left by 2 (alu_b_sel=3) to the already incremented PC with pc_we=1. A taken branch takes 6 cycles and an untaken one takes 5.
- R8: Any other opcode, or opcode 0x00 with a function other than 0x20, leads from decode to an error state. In that state every write strobe is 0 and mem_req=0 (no access), and the controller stays there until reset.
- R9: At most one of pc_we, ir_we, ad_we, dt_we and rf_we is high in any cycle. mem_req never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_opcode | input | 6 | Instruction register bits 31:26 |
| ir_funct | input | 6 | Instruction register bits 5:0 |
| alu_zero | input | 1 | ALU result equals zero |
| pc_we | output | 1 | Program counter write strobe |
| ir_we | output | 1 | Instruction register write strobe |
| ad_we | output | 1 | Address register write strobe |
| dt_we | output | 1 | Data register write strobe |
| rf_we | output | 1 | Register file write strobe |
| rf_wsel | output | 1 | Write address: 0 rt, 1 rd |
| rf_rsel | output | 1 | Read address: 0 rs, 1 rt |
| rf_dsel | output | 1 | Write data: 0 ALU result, 1 data register |
| alu_a_sel | output | 1 | ALU A: 0 PC, 1 register read data |
| alu_b_sel | output | 3 | ALU B: 0 four, 1 sext imm, 2 address reg, 3 sext imm<<2, 4 zero |
| mem_addr_sel | output | 1 | Memory address: 0 PC, 1 address register |
| alu_op | output | 3 | 0 AND, 1 OR, 2 add, 6 subtract |
| mem_req | output | 2 | 0 none, 1 read, 2 write |

## Verification
The hardest case to reach from the ports is the taken branch. It needs alu_zero high in exactly the compare cycle, and that only happens when two registers hold equal values that earlier instructions produced. The bench therefore models the datapath around the controller and runs a short program. Two registers are made equal through an add, a store and a load, then a branch over a marker instruction must skip it. A second reset with an unknown opcode at address zero, and a trailing add with a bad function code, drive the controller into its error state.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int ALUOP_W = 3;
  localparam int BSEL_W  = 3;
  localparam int MREQ_W  = 2;

  typedef enum logic [3:0] {
    S_FETCH    = 4'd0,
    S_PC_INC   = 4'd1,
    S_DECODE   = 4'd2,
    S_RD_RS    = 4'd3,
    S_EXEC_R   = 4'd4,
    S_EXEC_I   = 4'd5,
    S_MEM_ADDR = 4'd6,
    S_MEM_RD   = 4'd7,
    S_WB_LOAD  = 4'd8,
    S_MEM_WR   = 4'd9,
    S_BR_CMP   = 4'd10,
    S_BR_TAKE  = 4'd11,
    S_ERROR    = 4'd12
  } mcf_state_e;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_LW    = 6'h23;
  localparam logic [OPC_W-1:0] OPC_SW    = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [FN_W-1:0]  FN_ADD    = 6'h20;

  localparam logic [ALUOP_W-1:0] ALU_AND = 3'd0;
  localparam logic [ALUOP_W-1:0] ALU_OR  = 3'd1;
  localparam logic [ALUOP_W-1:0] ALU_ADD = 3'd2;
  localparam logic [ALUOP_W-1:0] ALU_SUB = 3'd6;

  localparam logic [BSEL_W-1:0] B_FOUR    = 3'd0;
  localparam logic [BSEL_W-1:0] B_IMM     = 3'd1;
  localparam logic [BSEL_W-1:0] B_AD      = 3'd2;
  localparam logic [BSEL_W-1:0] B_IMM_SH2 = 3'd3;
  localparam logic [BSEL_W-1:0] B_ZERO    = 3'd4;

  localparam logic [MREQ_W-1:0] MREQ_NONE = 2'd0;
  localparam logic [MREQ_W-1:0] MREQ_RD   = 2'd1;
  localparam logic [MREQ_W-1:0] MREQ_WR   = 2'd2;

  typedef struct packed {
    logic               pc_we;
    logic               ir_we;
    logic               ad_we;
    logic               dt_we;
    logic               rf_we;
    logic               rf_wsel;
    logic               rf_rsel;
    logic               rf_dsel;
    logic               alu_a_sel;
    logic [BSEL_W-1:0]  alu_b_sel;
    logic               mem_addr_sel;
    logic [ALUOP_W-1:0] alu_op;
    logic [MREQ_W-1:0]  mem_req;
  } mcf_ctrl_t;

endpackage

// File: rtl/mcf_rst_sync.sv
module mcf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= 1'b1;
      end
      assign rst_q_n = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= {q[STAGES-2:0], 1'b1};
      end
      assign rst_q_n = q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mcf_next_state.sv
module mcf_next_state
  import mcf_pkg::*;
(
  input  mcf_state_e       state_q,
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  input  logic             alu_zero,
  output mcf_state_e       state_d
);
  mcf_state_e decode_target;

  always_comb begin
    unique case (opcode)
      OPC_RTYPE: decode_target = (funct == FN_ADD) ? S_RD_RS : S_ERROR;
      OPC_ADDI:  decode_target = S_EXEC_I;
      OPC_LW:    decode_target = S_MEM_ADDR;
      OPC_SW:    decode_target = S_MEM_ADDR;
      OPC_BEQ:   decode_target = S_RD_RS;
      default:   decode_target = S_ERROR;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_FETCH:    state_d = S_PC_INC;
      S_PC_INC:   state_d = S_DECODE;
      S_DECODE:   state_d = decode_target;
      S_RD_RS:    state_d = (opcode == OPC_BEQ) ? S_BR_CMP : S_EXEC_R;
      S_EXEC_R:   state_d = S_FETCH;
      S_EXEC_I:   state_d = S_FETCH;
      S_MEM_ADDR: state_d = (opcode == OPC_LW) ? S_MEM_RD : S_MEM_WR;
      S_MEM_RD:   state_d = S_WB_LOAD;
      S_WB_LOAD:  state_d = S_FETCH;
      S_MEM_WR:   state_d = S_FETCH;
      S_BR_CMP:   state_d = alu_zero ? S_BR_TAKE : S_FETCH;
      S_BR_TAKE:  state_d = S_FETCH;
      S_ERROR:    state_d = S_ERROR;
      default:    state_d = S_ERROR;
    endcase
  end
endmodule

// File: rtl/mcf_out_decode.sv
module mcf_out_decode
  import mcf_pkg::*;
(
  input  mcf_state_e state_q,
  output mcf_ctrl_t  ctrl
);
  always_comb begin
    ctrl           = '0;
    ctrl.alu_op    = ALU_ADD;
    ctrl.alu_b_sel = B_FOUR;
    ctrl.mem_req   = MREQ_NONE;
    case (state_q)
      S_FETCH: begin
        ctrl.mem_req      = MREQ_RD;
        ctrl.mem_addr_sel = 1'b0;
        ctrl.ir_we        = 1'b1;
      end
      S_PC_INC: begin
        ctrl.alu_a_sel = 1'b0;
        ctrl.alu_b_sel = B_FOUR;
        ctrl.pc_we     = 1'b1;
      end
      S_RD_RS: begin
        ctrl.rf_rsel   = 1'b0;
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = B_ZERO;
        ctrl.ad_we     = 1'b1;
      end
      S_EXEC_R: begin
        ctrl.rf_rsel   = 1'b1;
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = B_AD;
        ctrl.rf_we     = 1'b1;
        ctrl.rf_wsel   = 1'b1;
        ctrl.rf_dsel   = 1'b0;
      end
      S_EXEC_I: begin
        ctrl.rf_rsel   = 1'b0;
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = B_IMM;
        ctrl.rf_we     = 1'b1;
        ctrl.rf_wsel   = 1'b0;
        ctrl.rf_dsel   = 1'b0;
      end
      S_MEM_ADDR: begin
        ctrl.rf_rsel   = 1'b0;
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = B_IMM;
        ctrl.ad_we     = 1'b1;
      end
      S_MEM_RD: begin
        ctrl.mem_addr_sel = 1'b1;
        ctrl.mem_req      = MREQ_RD;
        ctrl.dt_we        = 1'b1;
      end
      S_WB_LOAD: begin
        ctrl.rf_we   = 1'b1;
        ctrl.rf_wsel = 1'b0;
        ctrl.rf_dsel = 1'b1;
      end
      S_MEM_WR: begin
        ctrl.mem_addr_sel = 1'b1;
        ctrl.mem_req      = MREQ_WR;
        ctrl.rf_rsel      = 1'b1;
      end
      S_BR_CMP: begin
        ctrl.rf_rsel   = 1'b1;
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = B_AD;
        ctrl.alu_op    = ALU_SUB;
      end
      S_BR_TAKE: begin
        ctrl.alu_a_sel = 1'b0;
        ctrl.alu_b_sel = B_IMM_SH2;
        ctrl.pc_we     = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mcf_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OPC_W-1:0]   ir_opcode,
  input  logic [FN_W-1:0]    ir_funct,
  input  logic               alu_zero,
  output logic               pc_we,
  output logic               ir_we,
  output logic               ad_we,
  output logic               dt_we,
  output logic               rf_we,
  output logic               rf_wsel,
  output logic               rf_rsel,
  output logic               rf_dsel,
  output logic               alu_a_sel,
  output logic [BSEL_W-1:0]  alu_b_sel,
  output logic               mem_addr_sel,
  output logic [ALUOP_W-1:0] alu_op,
  output logic [MREQ_W-1:0]  mem_req
);
  logic       rst_q_n;
  mcf_state_e state_q;
  mcf_state_e state_d;
  mcf_ctrl_t  ctrl;

  mcf_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  mcf_next_state u_next (
    .state_q  (state_q),
    .opcode   (ir_opcode),
    .funct    (ir_funct),
    .alu_zero (alu_zero),
    .state_d  (state_d)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) state_q <= S_FETCH;
    else          state_q <= state_d;
  end

  mcf_out_decode u_out (
    .state_q (state_q),
    .ctrl    (ctrl)
  );

  assign pc_we        = ctrl.pc_we;
  assign ir_we        = ctrl.ir_we;
  assign ad_we        = ctrl.ad_we;
  assign dt_we        = ctrl.dt_we;
  assign rf_we        = ctrl.rf_we;
  assign rf_wsel      = ctrl.rf_wsel;
  assign rf_rsel      = ctrl.rf_rsel;
  assign rf_dsel      = ctrl.rf_dsel;
  assign alu_a_sel    = ctrl.alu_a_sel;
  assign alu_b_sel    = ctrl.alu_b_sel;
  assign mem_addr_sel = ctrl.mem_addr_sel;
  assign alu_op       = ctrl.alu_op;
  assign mem_req      = ctrl.mem_req;
endmodule

// File: rtl/mcf_checker.sv
module mcf_checker
  import mcf_pkg::*;
(
  input logic               clk,
  input logic               rst_q_n,
  input mcf_state_e         state_q,
  input logic               alu_zero,
  input logic               pc_we,
  input logic               ir_we,
  input logic               ad_we,
  input logic               dt_we,
  input logic               rf_we,
  input logic               rf_dsel,
  input logic               alu_a_sel,
  input logic [BSEL_W-1:0]  alu_b_sel,
  input logic               mem_addr_sel,
  input logic [ALUOP_W-1:0] alu_op,
  input logic [MREQ_W-1:0]  mem_req
);
  AST_FETCH_THEN_INC: assert property (@(posedge clk) disable iff (!rst_q_n)
    ir_we |=> (pc_we && !alu_a_sel && alu_b_sel == B_FOUR && alu_op == ALU_ADD)); // R2

  AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rf_we && rf_dsel) |-> ($past(dt_we) && $past(mem_req) == MREQ_RD)); // R5

  AST_STORE_AT_AD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mem_req == MREQ_WR) |-> (mem_addr_sel && $past(ad_we))); // R6

  AST_TAKEN_AFTER_SUB: assert property (@(posedge clk) disable iff (!rst_q_n)
    (pc_we && alu_b_sel == B_IMM_SH2) |-> ($past(alu_op) == ALU_SUB && $past(alu_zero))); // R7

  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == S_ERROR) |=> (state_q == S_ERROR)); // R8

  AST_ERROR_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == S_ERROR) |-> (!pc_we && !ir_we && !ad_we && !dt_we && !rf_we && mem_req == MREQ_NONE)); // R8

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({pc_we, ir_we, ad_we, dt_we, rf_we})); // R9

  AST_MEMREQ_LEGAL: assert property (@(posedge clk) disable iff (!rst_q_n)
    mem_req != 2'd3); // R9
endmodule

bind mc_ctrl_fsm mcf_checker u_chk (
  .clk          (clk),
  .rst_q_n      (rst_q_n),
  .state_q      (state_q),
  .alu_zero     (alu_zero),
  .pc_we        (pc_we),
  .ir_we        (ir_we),
  .ad_we        (ad_we),
  .dt_we        (dt_we),
  .rf_we        (rf_we),
  .rf_dsel      (rf_dsel),
  .alu_a_sel    (alu_a_sel),
  .alu_b_sel    (alu_b_sel),
  .mem_addr_sel (mem_addr_sel),
  .alu_op       (alu_op),
  .mem_req      (mem_req)
);

// File: tb/mc_ctrl_fsm_tb.sv
module mc_ctrl_fsm_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [5:0] ir_opcode, ir_funct;
  logic alu_zero;
  logic pc_we, ir_we, ad_we, dt_we, rf_we, rf_wsel, rf_rsel, rf_dsel, alu_a_sel, mem_addr_sel;
  logic [2:0] alu_b_sel, alu_op;
  logic [1:0] mem_req;

  mc_ctrl_fsm u_dut (
    .clk(clk), .rst_n(rst_n), .ir_opcode(ir_opcode), .ir_funct(ir_funct), .alu_zero(alu_zero),
    .pc_we(pc_we), .ir_we(ir_we), .ad_we(ad_we), .dt_we(dt_we), .rf_we(rf_we),
    .rf_wsel(rf_wsel), .rf_rsel(rf_rsel), .rf_dsel(rf_dsel), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .mem_addr_sel(mem_addr_sel), .alu_op(alu_op), .mem_req(mem_req)
  );

  // ---------------- datapath model ----------------
  logic [31:0] pc, ir, ad, dt;
  logic [31:0] rf [32];
  logic [31:0] mem [64];
  logic        ld_en = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;

  logic [4:0]  rs, rt, rd, raddr, waddr;
  logic [31:0] simm, rf_rdata, alu_a, alu_b, alu_y, mem_addr, mem_rdata, wdata;

  assign ir_opcode = ir[31:26];
  assign ir_funct  = ir[5:0];
  assign rs = ir[25:21];
  assign rt = ir[20:16];
  assign rd = ir[15:11];
  assign simm = {{16{ir[15]}}, ir[15:0]};
  assign raddr = rf_rsel ? rt : rs;
  assign waddr = rf_wsel ? rd : rt;
  assign rf_rdata = (raddr == 5'd0) ? 32'd0 : rf[raddr];
  assign alu_a = alu_a_sel ? rf_rdata : pc;
  always_comb begin
    case (alu_b_sel)
      3'd0: alu_b = 32'd4;
      3'd1: alu_b = simm;
      3'd2: alu_b = ad;
      3'd3: alu_b = simm << 2;
      default: alu_b = 32'd0;
    endcase
    case (alu_op)
      3'd0: alu_y = alu_a & alu_b;
      3'd1: alu_y = alu_a | alu_b;
      3'd2: alu_y = alu_a + alu_b;
      3'd6: alu_y = alu_a - alu_b;
      default: alu_y = 32'd0;
    endcase
  end
  assign alu_zero  = (alu_y == 32'd0);
  assign mem_addr  = mem_addr_sel ? ad : pc;
  assign mem_rdata = mem[mem_addr[7:2]];
  assign wdata     = rf_dsel ? dt : alu_y;

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (rst_n && mem_req == 2'd2) mem[mem_addr[7:2]] <= rf_rdata;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0; ir <= '0; ad <= '0; dt <= '0;
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else begin
      if (pc_we) pc <= alu_y;
      if (ir_we && mem_req == 2'd1) ir <= mem_rdata;
      if (ad_we) ad <= alu_y;
      if (dt_we) dt <= mem_rdata;
      if (rf_we && waddr != 5'd0) rf[waddr] <= wdata;
    end
  end

  // ---------------- checking ----------------
  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  typedef struct {
    bit          is_mem;
    logic [31:0] key;
    logic [31:0] val;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int       len_q[$];

  task automatic push_reg(input int idx, input logic [31:0] v, input string tag);
    sb_item_t it;
    it.is_mem = 1'b0; it.key = idx; it.val = v; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic push_mem(input logic [31:0] a, input logic [31:0] v, input string tag);
    sb_item_t it;
    it.is_mem = 1'b1; it.key = a; it.val = v; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic push_len(input int n);
    len_q.push_back(n);
  endtask

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] s, input logic [4:0] t,
                                        input logic [15:0] imm);
    return {op, s, t, imm};
  endfunction

  function automatic logic [31:0] enc_r(input logic [4:0] s, input logic [4:0] t, input logic [4:0] d,
                                        input logic [5:0] fn);
    return {6'd0, s, t, d, 5'd0, fn};
  endfunction

  task automatic load_word(input int a, input logic [31:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a[5:0]; ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // monitor: pops the scoreboard on every register or memory write
  bit ir_we_d = 1'b1;
  bit started = 1'b0;
  bit inc_due = 1'b0;
  int cyc = 0;
  int bad_cycles = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      started = 1'b0; inc_due = 1'b0; cyc = 0;
    end else begin
      if (inc_due) begin
        chk(pc_we && !alu_a_sel && alu_b_sel == 3'd0 && alu_op == 3'd2, "R2 pc increment after fetch",
            {pc_we, alu_a_sel, alu_b_sel, alu_op}, {1'b1, 1'b0, 3'd0, 3'd2});
        inc_due = 1'b0;
      end
      if (ir_we && !ir_we_d) begin
        if (started) begin
          if (len_q.size() == 0) chk(1'b0, "R3..R7 unexpected instruction end", cyc, 0);
          else begin
            int e;
            e = len_q.pop_front();
            chk(cyc == e, "R3/R4/R5/R6/R7 instruction length", cyc, e);
          end
        end
        started = 1'b1; cyc = 1; inc_due = 1'b1;
      end else cyc++;
      if ((int'(pc_we) + int'(ir_we) + int'(ad_we) + int'(dt_we) + int'(rf_we)) > 1 || mem_req == 2'd3)
        bad_cycles++; // R9
      if (rf_we && waddr != 5'd0) begin
        if (sb_q.size() == 0) chk(1'b0, "R3..R7 unexpected register write", {27'd0, waddr}, 0);
        else begin
          sb_item_t it;
          it = sb_q.pop_front();
          chk(!it.is_mem && it.key == {27'd0, waddr}, {it.tag, " write target"}, {27'd0, waddr}, it.key);
          chk(wdata == it.val, {it.tag, " write data"}, wdata, it.val);
        end
      end
      if (mem_req == 2'd2) begin
        if (sb_q.size() == 0) chk(1'b0, "R6 unexpected store", mem_addr, 0);
        else begin
          sb_item_t it;
          it = sb_q.pop_front();
          chk(it.is_mem && it.key == mem_addr, {it.tag, " store address"}, mem_addr, it.key);
          chk(rf_rdata == it.val, {it.tag, " store data"}, rf_rdata, it.val);
        end
      end
    end
    ir_we_d = ir_we;
  end

  task automatic wait_quiet(input string req);
    int q = 0;
    int n = 0;
    while (q < 4 && n < 500) begin
      @(negedge clk);
      n++;
      if (!(pc_we | ir_we | ad_we | dt_we | rf_we) && mem_req == 2'd0) q++;
      else q = 0;
    end
    chk(q >= 4, req, q, 4);
  endtask

  task automatic check_error_quiet(input string req);
    bit ok = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (pc_we | ir_we | ad_we | dt_we | rf_we | (mem_req != 2'd0)) ok = 1'b0;
    end
    chk(ok, req, {pc_we, ir_we, ad_we, dt_we, rf_we, mem_req}, 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 0);
    finish_run();
  end

  initial begin
    // scenario 1: a program of every supported instruction, ending in a bad function code
    rst_n = 1'b0;
    load_word(0, enc_i(6'h08, 5'd0, 5'd1, 16'd5));        // addi $1,$0,5
    load_word(1, enc_i(6'h08, 5'd0, 5'd2, 16'hFFFD));     // addi $2,$0,-3
    load_word(2, enc_r(5'd1, 5'd2, 5'd3, 6'h20));         // add  $3,$1,$2
    load_word(3, enc_i(6'h2B, 5'd0, 5'd3, 16'd128));      // sw   $3,128($0)
    load_word(4, enc_i(6'h23, 5'd0, 5'd4, 16'd128));      // lw   $4,128($0)
    load_word(5, enc_i(6'h04, 5'd3, 5'd4, 16'd1));        // beq  $3,$4,+1 (taken)
    load_word(6, enc_i(6'h08, 5'd0, 5'd5, 16'd99));       // addi $5 (must be skipped)
    load_word(7, enc_i(6'h04, 5'd1, 5'd2, 16'd1));        // beq  $1,$2,+1 (not taken)
    load_word(8, enc_i(6'h08, 5'd1, 5'd6, 16'd7));        // addi $6,$1,7
    load_word(9, enc_r(5'd1, 5'd2, 5'd7, 6'h22));         // bad function code
    @(negedge clk);
    chk(ir_we && mem_req == 2'd1 && !mem_addr_sel && !pc_we && !ad_we && !dt_we && !rf_we,
        "R1 reset outputs", {ir_we, mem_req, mem_addr_sel, pc_we, ad_we, dt_we, rf_we},
        {1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});

    push_reg(1, 32'd5, "R4 addi positive");
    push_reg(2, 32'hFFFF_FFFD, "R4 addi sign-extended");
    push_reg(3, 32'd2, "R3 add rd");
    push_mem(32'd128, 32'd2, "R6 sw");
    push_reg(4, 32'd2, "R5 lw rt");
    push_reg(6, 32'd12, "R4 addi after untaken R7 branch");
    push_len(4);  // addi $2
    push_len(5);  // add
    push_len(5);  // sw
    push_len(6);  // lw
    push_len(6);  // beq taken
    push_len(5);  // beq not taken
    push_len(4);  // addi $6

    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ir_we && mem_req == 2'd1, "R1 fetch held during synchronized release", {ir_we, mem_req},
        {1'b1, 2'd1});
    wait_quiet("R8 bad function reaches quiet error state");
    chk(sb_q.size() == 0, "R3/R4/R5/R6 all writes seen", sb_q.size(), 0);
    chk(len_q.size() == 0, "R7 all instructions completed", len_q.size(), 0);
    chk(rf[5] == 32'd0, "R7 taken branch skipped marker", rf[5], 0);
    chk(pc == 32'd40, "R8 error after decode of word 9", pc, 32'd40);
    check_error_quiet("R8 error state holds quiet");

    // scenario 2: unknown opcode at address zero
    rst_n = 1'b0;
    load_word(0, 32'hFC00_0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check_error_quiet("R8 unknown opcode trapped");
    chk(sb_q.size() == 0 && ir == 32'hFC00_0000, "R8 no write after unknown opcode", ir, 32'hFC00_0000);
    chk(bad_cycles == 0, "R9 single strobe and legal request", bad_cycles, 0);
    finish_run();
  end
endmodule